// File: doc/BRIEF.md
# SD Host Data-Ready Flag Tracker

This block holds the level flag that tells an SD/MMC host whether it may start a new data transfer. The host's command and data engines send it single-cycle event strobes: a data command was issued, a host command ended, a card response ended, a data block ended, and a stop-transmission command ended. The block also watches the sampled DAT0 line. From these it decides when the flag drops and when it rises again. The CRC, FIFOs and the engines themselves are outside the block.

When a data command is issued, the block latches its transfer kind and block count and becomes armed. Reads drop the flag when the host command ends. Writes drop it when the card response ends. The point where the flag rises again depends on the kind. A single-block read rises when its block ends. A counted multi-block read rises when its last counted block ends. An open-ended multi-block read rises only when the stop command ends. A write rises once the card stops holding DAT0 low for busy.

Top module: `sd_ready_tracker`

## Requirements
- R1: After reset `ready` is 1. It stays 1 while no transfer has dropped it, including after `cmd_issue` arms a transfer.
- R2: For a write (kind 2'b00), `ready` goes to 0 in the cycle after `rsp_end` is sampled. `cmd_end` has no effect on a write.
- R3: While a write holds `ready` at 0, each cycle with `dat0` sampled at 0 keeps it at 0. The first cycle with `dat0` sampled at 1 sets `ready` to 1 in the next cycle.
- R4: For any read kind (2'b01, 2'b10, 2'b11), `ready` goes to 0 in the cycle after `cmd_end` is sampled. `rsp_end` has no effect on a read.
- R5: For a single-block read (kind 2'b01), `ready` returns to 1 in the cycle after `blk_end`.
- R6: For a counted read (kind 2'b10), the count is latched from `blk_count` at `cmd_issue`. `ready` returns to 1 in the cycle after the count-th `blk_end`. A count of 0 behaves like 1.
- R7: For an open-ended read (kind 2'b11), `blk_end` has no effect, and `ready` returns to 1 in the cycle after `stop_end`.
- R8: A strobe that does not belong to the active transfer has no effect on `ready`. This covers `stop_end` outside an open-ended read, `blk_end` during a write, `dat0` during a read, and every strobe when no transfer is armed.
- R9: `cmd_issue` is ignored while `ready` is 0. While a transfer is armed, a new `cmd_issue` replaces its kind and count. In the cycle it is sampled, `cmd_issue` takes priority over other strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_issue | input | 1 | Data command issued; latches kind and count |
| xfer_kind | input | 2 | 00 write, 01 single read, 10 counted read, 11 open read |
| blk_count | input | CNT_W | Block count for counted reads |
| cmd_end | input | 1 | End of host command strobe |
| rsp_end | input | 1 | End of card response strobe |
| blk_end | input | 1 | End of data block strobe |
| stop_end | input | 1 | End of stop-transmission command strobe |
| dat0 | input | 1 | Sampled DAT0 line level |
| ready | output | 1 | 1 when a new data transfer may start |

## Verification
The bench builds the block with `CNT_W` set to 4. This makes the largest block count, 15, and the count-of-zero case cheap to reach in directed runs. Random runs use short counts, so counted reads finish often, and they mix foreign strobes and DAT0 noise into every phase of every transfer kind.

// File: rtl/sd_ready_tracker.sv
module sd_ready_tracker #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_issue,
  input  logic [1:0]       xfer_kind,
  input  logic [CNT_W-1:0] blk_count,
  input  logic             cmd_end,
  input  logic             rsp_end,
  input  logic             blk_end,
  input  logic             stop_end,
  input  logic             dat0,
  output logic             ready
);
  localparam logic [1:0] K_WR = 2'b00, K_RS = 2'b01, K_RC = 2'b10, K_RO = 2'b11;

  typedef enum logic [2:0] {S_IDLE, S_ARM, S_WBUSY, S_RSING, S_RCNT, S_ROPEN} st_t;

  st_t              st_q;
  logic [1:0]       kind_q;
  logic [CNT_W-1:0] cnt_q;

  wire last_blk = (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      kind_q <= K_WR;
      cnt_q  <= '0;
    end else if (cmd_issue && (st_q == S_IDLE || st_q == S_ARM)) begin
      st_q   <= S_ARM;
      kind_q <= xfer_kind;
      cnt_q  <= blk_count;
    end else begin
      unique case (st_q)
        S_ARM: begin
          if (kind_q == K_WR) begin
            if (rsp_end) st_q <= S_WBUSY;
          end else if (cmd_end) begin
            unique case (kind_q)
              K_RS:    st_q <= S_RSING;
              K_RC:    st_q <= S_RCNT;
              default: st_q <= S_ROPEN;
            endcase
          end
        end
        S_WBUSY: if (dat0) st_q <= S_IDLE;
        S_RSING: if (blk_end) st_q <= S_IDLE;
        S_RCNT: if (blk_end) begin
          if (last_blk) st_q <= S_IDLE;
          else cnt_q <= cnt_q - CNT_W'(1);
        end
        S_ROPEN: if (stop_end) st_q <= S_IDLE;
        default: ;
      endcase
    end
  end

  assign ready = (st_q == S_IDLE) || (st_q == S_ARM);
endmodule

// File: rtl/sd_ready_tracker_chk.sv
module sd_ready_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ready,
  input logic       cmd_end,
  input logic       rsp_end,
  input logic       blk_end,
  input logic       stop_end,
  input logic       dat0,
  input logic [1:0] kind_q
);
  // R2
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(cmd_end || rsp_end));
  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(blk_end || stop_end || dat0));
  // R3
  wr_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && kind_q == 2'b00 && !dat0) |=> !ready);
  // R5
  single_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && kind_q == 2'b01 && !blk_end) |=> !ready);
  // R7
  open_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && kind_q == 2'b11 && !stop_end) |=> !ready);
  // R9
  kind_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && $past(!ready)) |-> $stable(kind_q));
endmodule

bind sd_ready_tracker sd_ready_tracker_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready), .cmd_end(cmd_end),
  .rsp_end(rsp_end), .blk_end(blk_end), .stop_end(stop_end),
  .dat0(dat0), .kind_q(kind_q)
);

// File: tb/sd_ready_tracker_bench.sv
module sd_ready_tracker_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  logic cmd_issue = 0, cmd_end = 0, rsp_end = 0, blk_end = 0, stop_end = 0, dat0 = 1;
  logic [1:0] xfer_kind = 0;
  logic [CW-1:0] blk_count = 0;
  logic ready;
  int checks = 0, fails = 0;
  bit done = 0;

  // reference state: 0 idle, 1 armed, 2 write busy, 3 single, 4 counted, 5 open
  int m_st = 0;
  logic [1:0] m_kind = 0;
  int m_cnt = 0;

  sd_ready_tracker #(.CNT_W(CW)) u_sd_ready_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_issue(cmd_issue), .xfer_kind(xfer_kind),
    .blk_count(blk_count), .cmd_end(cmd_end), .rsp_end(rsp_end),
    .blk_end(blk_end), .stop_end(stop_end), .dat0(dat0), .ready(ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit exp_ready();
    return (m_st <= 1);
  endfunction

  task automatic model();
    if (cmd_issue && m_st <= 1) begin
      m_st = 1; m_kind = xfer_kind; m_cnt = (blk_count == 0) ? 1 : int'(blk_count);
    end else case (m_st)
      1: if (m_kind == 2'b00) begin if (rsp_end) m_st = 2; end
         else if (cmd_end) m_st = (m_kind == 2'b01) ? 3 : (m_kind == 2'b10) ? 4 : 5;
      2: if (dat0) m_st = 0;
      3: if (blk_end) m_st = 0;
      4: if (blk_end) begin m_cnt--; if (m_cnt == 0) m_st = 0; end
      5: if (stop_end) m_st = 0;
      default: ;
    endcase
  endtask

  task automatic check(input string tag);
    checks++;
    if (ready !== exp_ready()) begin
      fails++;
      $display("FAIL %s: ready=%0b expected=%0b", tag, ready, exp_ready());
    end
  endtask

  task automatic step(input bit iss, input logic [1:0] k, input int n,
                      input bit ce, input bit re, input bit be, input bit se,
                      input bit d, input string tag);
    @(negedge clk);
    cmd_issue = iss; xfer_kind = k; blk_count = CW'(n);
    cmd_end = ce; rsp_end = re; blk_end = be; stop_end = se; dat0 = d;
    model();
    @(posedge clk); #1;
    check(tag);
  endtask

  task automatic idle(input int c, input bit d, input string tag);
    for (int i = 0; i < c; i++) step(0, 0, 0, 0, 0, 0, 0, d, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1 check("R1 reset");
    idle(2, 1, "R1");
    step(0, 0, 0, 1, 1, 1, 1, 0, "R8 idle strobes");
    // write
    step(1, 2'b00, 0, 0, 0, 0, 0, 0, "R1 armed");
    step(0, 0, 0, 1, 0, 0, 0, 0, "R2 cmd_end ignored");
    step(0, 0, 0, 0, 1, 0, 0, 0, "R2 drop");
    step(0, 0, 0, 0, 0, 1, 1, 0, "R8 write foreign");
    step(1, 2'b01, 0, 0, 0, 0, 0, 0, "R9 issue ignored");
    idle(3, 0, "R3 busy");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R3 release");
    // single read
    step(1, 2'b01, 0, 0, 0, 0, 0, 1, "R1");
    step(0, 0, 0, 0, 1, 0, 0, 1, "R4 rsp ignored");
    step(0, 0, 0, 1, 0, 0, 0, 1, "R4 drop");
    step(0, 0, 0, 0, 0, 0, 1, 1, "R8 dat0/stop ignored");
    step(0, 0, 0, 0, 0, 1, 0, 1, "R5 release");
    // counted: max and zero
    step(1, 2'b10, 15, 0, 0, 0, 0, 1, "R6");
    step(0, 0, 0, 1, 0, 0, 0, 1, "R4");
    for (int i = 0; i < 15; i++) step(0, 0, 0, 0, 0, 1, 0, 1, "R6 count15");
    step(1, 2'b10, 0, 0, 0, 0, 0, 1, "R6");
    step(0, 0, 0, 1, 0, 0, 0, 1, "R4");
    step(0, 0, 0, 0, 0, 1, 0, 1, "R6 zero");
    // re-latch while armed
    step(1, 2'b10, 3, 0, 0, 0, 0, 1, "R9");
    step(1, 2'b11, 1, 1, 0, 0, 0, 1, "R9 relatch priority");
    step(0, 0, 0, 1, 0, 0, 0, 1, "R4");
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 1, 0, 1, "R7 blk ignored");
    step(0, 0, 0, 0, 0, 0, 1, 1, "R7 release");
    // random
    void'($urandom(32'h5D2A));
    for (int i = 0; i < 5000; i++) begin
      logic [1:0] k = 2'($urandom_range(3));
      step(($urandom_range(9) == 0), k, $urandom_range(4),
           ($urandom_range(5) == 0), ($urandom_range(5) == 0),
           ($urandom_range(3) == 0), ($urandom_range(9) == 0),
           ($urandom_range(2) == 0), "R8 random");
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: ended=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule